// File: doc/BRIEF.md
# Receive FIFO Character Timeout Detector

This block sits next to the receive FIFO of a 16550-style UART. It raises a flag for the interrupt identification logic when characters have sat in the FIFO with no traffic for four character times. The detector counts 16x baud ticks. The length of its window comes from the programmed frame format: data width, parity and stop bits. The FIFO storage and the serial receiver are outside this block. It only observes the FIFO's push, pop and not-empty signals, the receive-buffer read strobe and the FIFO-mode enable.

Three states drive the block:

- **IDLE**: the counter is held at zero and the flag is low.
- **COUNT**: the window is running.
- **EXPIRED**: the flag is high.

Its transitions are:

- **IDLE→COUNT (arm)**: FIFO mode is on and the FIFO holds data. The window counter clears and the window length is captured from the current format.
- **COUNT→COUNT (restart)**: a push, a pop or a receive-buffer read clears the counter and captures the window length again.
- **COUNT→EXPIRED (expire)**: the tick that completes the window arrives with no restart in the same cycle.
- **EXPIRED→COUNT (clear)**: a receive-buffer read, push or pop drops the flag and restarts the window.
- **COUNT/EXPIRED→IDLE (drain)**: the FIFO becomes empty or FIFO mode is switched off.

Top module: `ctd_rx_timeout`

## Requirements
- R1: After reset the timeout flag is low.
- R2: Arming and timing.
  - The window counter arms in the cycle after FIFO mode is on with the FIFO non-empty.
  - The flag rises at the clock edge that samples the tick completing the window, provided no restart happens in that cycle.
  - The window is 4 × (16 × (1 + data bits + parity bit) + stop ticks) ticks of `tick16_i`.
- R3: `word_len_i` selects the number of data bits: 2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8.
- R4: `parity_en_i` = 1 adds one bit time (16 ticks) to each character.
- R5: Stop ticks per character depend on `stop_sel_i` and the data width.
  - `stop_sel_i` = 0 gives 16 ticks.
  - `stop_sel_i` = 1 gives 32 ticks, except with 5 data bits, where it gives 24 ticks (1.5 stop bits).
- R6: A push or pop restarts the window from zero, and a tick in the same cycle is not counted.
- R7: A receive-buffer read clears the flag in the next cycle and restarts the window.
- R8: While the FIFO is empty the counter stays at zero and the flag is low; the flag drops the cycle after the FIFO empties.
- R9: While FIFO mode is off the counter stays at zero and the flag is low.
- R10: A change of frame format takes effect only at the next arm or restart; a window already running keeps its captured length.
- R11: Once set, the flag stays high through further ticks until it is cleared by R7, R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO mode enabled |
| push_i | input | 1 | Character written into the receive FIFO |
| pop_i | input | 1 | Character removed from the receive FIFO |
| rbr_read_i | input | 1 | Receive buffer register read |
| not_empty_i | input | 1 | Receive FIFO holds at least one character |
| word_len_i | input | 2 | Data-bit count code |
| parity_en_i | input | 1 | Parity bit present |
| stop_sel_i | input | 1 | Long stop selection |
| tick16_i | input | 1 | One-cycle pulse at 16x baud rate |
| timeout_o | output | 1 | Character timeout indication |

## Verification
The hardest case to reach is a format change while a window is running. Timing must follow the old length until the window expires, then the new length after the next restart. Reaching it takes hundreds of ticks with the FIFO held non-empty and no FIFO traffic. The bench arms with a 5-bit frame, switches to 8 bits after ten ticks, and checks the flag one tick either side of the old boundary. It then pushes and checks the new boundary. All sixteen format combinations are swept to their exact edge, both after arming and after a read-triggered restart.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_EXPIRED  = 2'd2
    } ctd_state_e;

endpackage

// File: rtl/ctd_frame_calc.sv
module ctd_frame_calc #(
    parameter int OVERSAMPLE  = 16,
    parameter int CHARS       = 4,
    parameter bit SHORT_HALF  = 1'b1,
    parameter int CW          = 10
) (
    input  logic [1:0]    word_len_i,
    input  logic          parity_en_i,
    input  logic          stop_sel_i,
    output logic [CW-1:0] window_o
);

    localparam int BIT_T     = OVERSAMPLE;
    localparam int MIN_DATA  = 5;

    int long_stop_short;
    int data_bits;
    int par_bits;
    int stop_ticks;
    int char_ticks;

    // Long stop on the shortest word: 1.5 bits, or a full 2 bits.
    generate
        if (SHORT_HALF) begin : g_half_stop
            assign long_stop_short = BIT_T + BIT_T / 2;
        end else begin : g_full_stop
            assign long_stop_short = 2 * BIT_T;
        end
    endgenerate

    always_comb begin
        data_bits = MIN_DATA + int'(word_len_i);
        par_bits  = parity_en_i ? 1 : 0;

        if (!stop_sel_i) begin
            stop_ticks = BIT_T;
        end else if (word_len_i == 2'b00) begin
            stop_ticks = long_stop_short;
        end else begin
            stop_ticks = 2 * BIT_T;
        end

        char_ticks = BIT_T * (1 + data_bits + par_bits) + stop_ticks;
        window_o   = CW'(CHARS * char_ticks);
    end

endmodule

// File: rtl/ctd_window_cnt.sv
module ctd_window_cnt #(
    parameter int CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] new_window_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] lim_o,
    output logic          hit_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= new_window_i;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign hit_o = run_i && tick_i && ((cnt_q + CW'(1)) == lim_q);
    assign cnt_o = cnt_q;
    assign lim_o = lim_q;

endmodule

// File: rtl/ctd_rx_timeout.sv
module ctd_rx_timeout
    import ctd_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int CHARS      = 4,
    parameter bit SHORT_HALF = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fifo_en_i,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic       rbr_read_i,
    input  logic       not_empty_i,
    input  logic [1:0] word_len_i,
    input  logic       parity_en_i,
    input  logic       stop_sel_i,
    input  logic       tick16_i,
    output logic       timeout_o
);

    // Longest character: start + 8 data + parity + 2 stop bits.
    localparam int MAX_BITS   = 12;
    localparam int MAX_WINDOW = CHARS * OVERSAMPLE * MAX_BITS;
    localparam int CNT_W      = $clog2(MAX_WINDOW + 1);

    ctd_state_e    state_q;
    ctd_state_e    state_d;
    logic          active;
    logic          restart;
    logic          load;
    logic          clr;
    logic          run;
    logic          hit;
    logic [CNT_W-1:0] new_window;
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] win_lim;

    assign active  = fifo_en_i && not_empty_i;
    assign restart = push_i || pop_i || rbr_read_i;

    ctd_frame_calc #(
        .OVERSAMPLE (OVERSAMPLE),
        .CHARS      (CHARS),
        .SHORT_HALF (SHORT_HALF),
        .CW         (CNT_W)
    ) u_frame (
        .word_len_i  (word_len_i),
        .parity_en_i (parity_en_i),
        .stop_sel_i  (stop_sel_i),
        .window_o    (new_window)
    );

    ctd_window_cnt #(
        .CW (CNT_W)
    ) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_i       (load),
        .clr_i        (clr),
        .run_i        (run),
        .tick_i       (tick16_i),
        .new_window_i (new_window),
        .cnt_o        (win_cnt),
        .lim_o        (win_lim),
        .hit_o        (hit)
    );

    // Next-state logic and counter controls.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        clr     = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr = 1'b1;
                if (active) begin
                    state_d = ST_COUNT;
                    load    = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!active) begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end else if (restart) begin
                    load = 1'b1;
                end else begin
                    run = 1'b1;
                    if (hit) begin
                        state_d = ST_EXPIRED;
                    end
                end
            end
            ST_EXPIRED: begin
                if (!active) begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end else if (restart) begin
                    state_d = ST_COUNT;
                    load    = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                clr     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        timeout_o = (state_q == ST_EXPIRED);
    end

endmodule

module ctd_rx_timeout_chk
    import ctd_pkg::*;
#(
    parameter int CW = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          fifo_en_i,
    input logic          push_i,
    input logic          pop_i,
    input logic          rbr_read_i,
    input logic          not_empty_i,
    input logic          tick16_i,
    input logic          timeout_o,
    input ctd_state_e    state_i,
    input logic [CW-1:0] cnt_i,
    input logic [CW-1:0] lim_i
);

    logic restart_w;
    assign restart_w = push_i || pop_i || rbr_read_i;

    p_rise_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> ($past(tick16_i) && $past(state_i == ST_COUNT)));

    p_cnt_below_lim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_COUNT) |-> (cnt_i < lim_i));

    p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_w && fifo_en_i && not_empty_i) |=> (cnt_i == '0));

    p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rbr_read_i |=> !timeout_o);

    p_empty_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !not_empty_i |=> (!timeout_o && cnt_i == '0));

    p_disabled_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fifo_en_i |=> (!timeout_o && cnt_i == '0));

    p_lim_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_COUNT && !restart_w) |=> $stable(lim_i));

    p_flag_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && fifo_en_i && not_empty_i && !restart_w) |=> timeout_o);

endmodule

bind ctd_rx_timeout ctd_rx_timeout_chk #(.CW(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .rbr_read_i  (rbr_read_i),
    .not_empty_i (not_empty_i),
    .tick16_i    (tick16_i),
    .timeout_o   (timeout_o),
    .state_i     (state_q),
    .cnt_i       (win_cnt),
    .lim_i       (win_lim)
);

// File: tb/test_ctd_rx_timeout.sv
`timescale 1ns/1ps
module test_ctd_rx_timeout;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       push = 1'b0;
    logic       pop = 1'b0;
    logic       rbr_read = 1'b0;
    logic       not_empty = 1'b0;
    logic [1:0] word_len = 2'b00;
    logic       parity_en = 1'b0;
    logic       stop_sel = 1'b0;
    logic       tick = 1'b0;
    logic       timeout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctd_rx_timeout i_ctd_rx_timeout (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fifo_en_i   (fifo_en),
        .push_i      (push),
        .pop_i       (pop),
        .rbr_read_i  (rbr_read),
        .not_empty_i (not_empty),
        .word_len_i  (word_len),
        .parity_en_i (parity_en),
        .stop_sel_i  (stop_sel),
        .tick16_i    (tick),
        .timeout_o   (timeout)
    );

    function automatic int window_of(int w, bit p, bit s);
        int stop_t;
        if (!s)          stop_t = 16;
        else if (w == 0) stop_t = 24;
        else             stop_t = 32;
        return 4 * (16 * (1 + 5 + w + (p ? 1 : 0)) + stop_t);
    endfunction

    task automatic chk(input bit exp, input string req);
        checks++;
        if (timeout !== exp) begin
            errors++;
            $display("FAIL %s: timeout=%b expected=%b", req, timeout, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_push();
        push = 1'b1; @(negedge clk); push = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1; @(negedge clk); pop = 1'b0;
    endtask

    task automatic do_read();
        rbr_read = 1'b1; @(negedge clk); rbr_read = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lim;
        repeat (3) @(negedge clk);
        chk(1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R1 after reset");
        fifo_en = 1'b1;

        // Sweep every frame format (R2, R3, R4, R5, R7, R8).
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 2; s++) begin
                    word_len  = 2'(w);
                    parity_en = p[0];
                    stop_sel  = s[0];
                    lim = window_of(w, p[0], s[0]);
                    not_empty = 1'b1;
                    @(negedge clk);
                    ticks(lim - 1);
                    chk(1'b0, "R2 R3 R4 R5 one tick short");
                    ticks(1);
                    chk(1'b1, "R2 R3 R4 R5 window edge");
                    ticks(3);
                    chk(1'b1, "R11 holds after extra ticks");
                    do_read();
                    chk(1'b0, "R7 read clears");
                    ticks(lim - 1);
                    chk(1'b0, "R7 restart one tick short");
                    ticks(1);
                    chk(1'b1, "R7 restarted window edge");
                    not_empty = 1'b0;
                    @(negedge clk);
                    chk(1'b0, "R8 empty drops flag");
                end
            end
        end

        // Restart by push with a simultaneous tick (R6).
        word_len = 2'b11; parity_en = 1'b0; stop_sel = 1'b0;
        lim = window_of(3, 1'b0, 1'b0);
        not_empty = 1'b1;
        @(negedge clk);
        ticks(300);
        push = 1'b1; tick = 1'b1;
        @(negedge clk);
        push = 1'b0; tick = 1'b0;
        @(negedge clk);
        ticks(lim - 1);
        chk(1'b0, "R6 push restart, same-cycle tick ignored");
        ticks(1);
        chk(1'b1, "R6 push restart window edge");

        // Restart by pop (R6).
        do_read();
        ticks(200);
        do_pop();
        ticks(lim - 1);
        chk(1'b0, "R6 pop restart one tick short");
        ticks(1);
        chk(1'b1, "R6 pop restart window edge");
        do_push();
        chk(1'b0, "R6 push clears expired flag");

        // Format change mid-window (R10).
        not_empty = 1'b0;
        @(negedge clk);
        word_len = 2'b00;
        not_empty = 1'b1;
        @(negedge clk);
        ticks(10);
        word_len = 2'b11;
        ticks(window_of(0, 1'b0, 1'b0) - 11);
        chk(1'b0, "R10 old window one tick short");
        ticks(1);
        chk(1'b1, "R10 old window kept");
        do_push();
        ticks(window_of(3, 1'b0, 1'b0) - 1);
        chk(1'b0, "R10 new window one tick short");
        ticks(1);
        chk(1'b1, "R10 new window after restart");

        // FIFO mode off (R9).
        fifo_en = 1'b0;
        @(negedge clk);
        chk(1'b0, "R9 disable drops flag");
        ticks(800);
        chk(1'b0, "R9 no timeout while disabled");
        fifo_en = 1'b1;
        @(negedge clk);
        ticks(lim - 1);
        chk(1'b0, "R9 fresh window after enable");
        ticks(1);
        chk(1'b1, "R9 window edge after enable");

        // Empty FIFO holds the counter (R8).
        not_empty = 1'b0;
        @(negedge clk);
        ticks(800);
        chk(1'b0, "R8 no timeout while empty");
        not_empty = 1'b1;
        @(negedge clk);
        ticks(lim - 1);
        chk(1'b0, "R8 counter was held at zero");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule